// File: doc/BRIEF.md
# Operand-Selecting 16-bit Arithmetic/Logic Unit

This block is the execute stage arithmetic unit of a small eight-register processor. It receives two register source values and the current instruction word. It conditions two immediates taken from the instruction: an upper immediate shifted into the high bits, and a short signed immediate widened by sign extension. A separate one-bit select for each operand chooses between the register value and its immediate.

A two-bit function code then applies one of four operations to the chosen operands: add, bitwise NAND, pass the first operand, or compare. The unit produces a 16-bit result. It also produces an equality flag, which is computed on every evaluation whatever the function code.

The unit is purely combinational and has no clock or reset. The surrounding pipeline registers its outputs where it needs them.

Top module: `alu16_opmux`

## Requirements
- R1: With `func` = 2'b00, `result` is (operand A + operand B) modulo 2^16. A carry out of bit 15 is discarded and no carry or overflow output exists.
- R2: With `func` = 2'b01, `result` is the bitwise complement of (operand A AND operand B).
- R3: With `func` = 2'b10, `result` equals operand A unchanged.
- R4: With `func` = 2'b11 (compare), `result` is 16'h0000.
- R5: `equal` is 1 exactly when operand A equals operand B, for every value of `func`.
- R6: With `sel_a` = 0, operand A is `src_a`. With `sel_a` = 1, operand A is `instr[9:0]` placed in bits 15:6, with bits 5:0 zero.
- R7: With `sel_b` = 0, operand B is `src_b`. With `sel_b` = 1, operand B is `instr[6:0]` as a two's-complement value, with bit 6 copied into bits 15:7.
- R8: The outputs depend only on the current inputs. They settle within the same cycle the inputs change, and hold no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 16 | First register source value |
| src_b | input | 16 | Second register source value |
| instr | input | 16 | Instruction word carrying both immediates |
| sel_a | input | 1 | 1 selects the shifted upper immediate as operand A |
| sel_b | input | 1 | 1 selects the sign-extended immediate as operand B |
| func | input | 2 | Operation: 00 add, 01 NAND, 10 pass A, 11 compare |
| result | output | 16 | Operation result |
| equal | output | 1 | Operand A equals operand B |

## Verification
The equality flag and the selected operation are produced at the same time, so both outputs must be judged on every vector. The key case is when the operands are equal under add, NAND or pass. There the flag must rise while `result` still carries the operation's value, not the zero that compare drives.

The bench provokes this in three ways:
- Operand lists in which every value meets itself.
- The immediate paths producing equal operands, such as `src_b` matching the sign-extended immediate.
- Equal pairs under all four function codes.

For each vector, the expected result and the expected flag are computed independently in the bench and compared separately.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_NAND = 2'b01,
    FN_PASS = 2'b10,
    FN_CMP  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/alu16_operand.sv
module alu16_operand #(
  parameter int DATA_W = 16,
  parameter int UIMM_W = 10,
  parameter int SIMM_W = 7
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] instr,
  input  logic              sel_a,
  input  logic              sel_b,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  localparam int SHIFT = DATA_W - UIMM_W;
  localparam int EXT_W = DATA_W - SIMM_W;

  logic [DATA_W-1:0] upper_imm;
  logic [DATA_W-1:0] signed_imm;

  generate
    if (SHIFT > 0) begin : g_upper_shift
      assign upper_imm = {instr[UIMM_W-1:0], {SHIFT{1'b0}}};
    end else begin : g_upper_full
      assign upper_imm = instr[DATA_W-1:0];
    end
  endgenerate

  generate
    if (EXT_W > 0) begin : g_sext
      assign signed_imm = {{EXT_W{instr[SIMM_W-1]}}, instr[SIMM_W-1:0]};
    end else begin : g_sext_full
      assign signed_imm = instr[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    op_a = sel_a ? upper_imm : src_a;
    op_b = sel_b ? signed_imm : src_b;
  end
endmodule

// File: rtl/alu16_eq.sv
module alu16_eq #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              eq
);
  logic [DATA_W-1:0] diff;

  always_comb begin
    diff = op_a ^ op_b;
    eq   = ~|diff;
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        func,
  output logic [DATA_W-1:0] result
);
  alu_fn_e fn;

  always_comb begin
    fn = alu_fn_e'(func);
    case (fn)
      FN_ADD:  result = op_a + op_b;
      FN_NAND: result = ~(op_a & op_b);
      FN_PASS: result = op_a;
      FN_CMP:  result = '0;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/alu16_opmux.sv
module alu16_opmux #(
  parameter int DATA_W = 16,
  parameter int UIMM_W = 10,
  parameter int SIMM_W = 7
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] instr,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic [1:0]        func,
  output logic [DATA_W-1:0] result,
  output logic              equal
);
  logic [DATA_W-1:0] op_a;
  logic [DATA_W-1:0] op_b;

  alu16_operand #(
    .DATA_W(DATA_W),
    .UIMM_W(UIMM_W),
    .SIMM_W(SIMM_W)
  ) operand_i (
    .src_a(src_a),
    .src_b(src_b),
    .instr(instr),
    .sel_a(sel_a),
    .sel_b(sel_b),
    .op_a (op_a),
    .op_b (op_b)
  );

  alu16_core #(.DATA_W(DATA_W)) core_i (
    .op_a  (op_a),
    .op_b  (op_b),
    .func  (func),
    .result(result)
  );

  alu16_eq #(.DATA_W(DATA_W)) eq_i (
    .op_a(op_a),
    .op_b(op_b),
    .eq  (equal)
  );
endmodule

// File: rtl/alu16_opmux_chk.sv
module alu16_opmux_chk #(
  parameter int DATA_W = 16
) (
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              sel_a,
  input logic              sel_b,
  input logic [1:0]        func,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [DATA_W-1:0] result,
  input logic              equal
);
  always_comb begin
    // R1
    add_inverse_chk: assert (func != 2'b00 || (result - op_b) == op_a);
    // R2
    nand_disjoint_chk: assert (func != 2'b01 || ((result & op_a & op_b) == '0 && (result | (op_a & op_b)) == '1));
    // R3
    pass_a_chk: assert (func != 2'b10 || result == op_a);
    // R4
    cmp_zero_chk: assert (func != 2'b11 || result == '0);
    // R5
    equal_flag_chk: assert (!equal || (op_a - op_b) == '0);
    // R6
    sel_a_reg_chk: assert (sel_a || op_a == src_a);
    // R7
    sel_b_reg_chk: assert (sel_b || op_b == src_b);
  end
endmodule

bind alu16_opmux alu16_opmux_chk #(.DATA_W(DATA_W)) chk_i (
  .src_a (src_a),
  .src_b (src_b),
  .sel_a (sel_a),
  .sel_b (sel_b),
  .func  (func),
  .op_a  (op_a),
  .op_b  (op_b),
  .result(result),
  .equal (equal)
);

// File: tb/alu16_opmux_tb.sv
module alu16_opmux_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [15:0] src_a, src_b, instr;
  logic        sel_a, sel_b;
  logic [1:0]  func;
  logic [15:0] result;
  logic        equal;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_opmux dut_i (
    .src_a (src_a),
    .src_b (src_b),
    .instr (instr),
    .sel_a (sel_a),
    .sel_b (sel_b),
    .func  (func),
    .result(result),
    .equal (equal)
  );

  localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000,
                                       16'h7FFF, 16'h0040, 16'hFFC0, 16'h1234};
  localparam logic [15:0] INSTRS [7] = '{16'h0000, 16'h003F, 16'h0040, 16'h03FF,
                                         16'h0155, 16'h007F, 16'hFFFF};

  function automatic logic [15:0] exp_a(logic [15:0] s, logic [15:0] ins, logic sel);
    return sel ? (ins[9:0] * 16'd64) : s;
  endfunction

  function automatic logic [15:0] exp_b(logic [15:0] s, logic [15:0] ins, logic sel);
    int v;
    v = int'(ins[6:0]);
    if (v >= 64) v = v - 128;
    return sel ? 16'(v) : s;
  endfunction

  function automatic logic [15:0] exp_res(logic [15:0] a, logic [15:0] b, logic [1:0] f);
    case (f)
      2'b00:   return 16'((int'(a) + int'(b)) % 65536);
      2'b01:   return 16'hFFFF - (a & b);
      2'b10:   return a;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check_val(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] a, logic [15:0] b, logic [15:0] ins,
                       logic sa, logic sb, logic [1:0] f);
    @(negedge clk);
    src_a = a; src_b = b; instr = ins; sel_a = sa; sel_b = sb; func = f;
    #1;
  endtask

  initial begin
    src_a = '0; src_b = '0; instr = '0; sel_a = 0; sel_b = 0; func = 2'b00;
    // R8: idle inputs give result zero and the flag set, no clock edge needed
    #1;
    check_val("R8 idle result", result, 16'h0000);
    check_val("R8 idle equal", {15'b0, equal}, 16'h0001);

    // R6: upper immediate 0x3FF shifted gives FFC0
    apply(16'h1111, 16'h0, 16'h03FF, 1, 0, 2'b10);
    check_val("R6 upper imm", result, 16'hFFC0);
    // R7: immediate 0x40 sign-extends to FFC0, add with src_a 0
    apply(16'h0000, 16'h5555, 16'h0040, 0, 1, 2'b00);
    check_val("R7 sign ext neg", result, 16'hFFC0);
    apply(16'h0000, 16'h5555, 16'h003F, 0, 1, 2'b00);
    check_val("R7 sign ext pos", result, 16'h003F);
    // R1: wrap 0xFFFF + 1 = 0
    apply(16'hFFFF, 16'h0001, 16'h0, 0, 0, 2'b00);
    check_val("R1 wrap", result, 16'h0000);
    // R5: flag set alongside add with equal operands
    apply(16'h1234, 16'h1234, 16'h0, 0, 0, 2'b00);
    check_val("R5 eq with add", {15'b0, equal}, 16'h0001);
    check_val("R1 sum with eq", result, 16'h2468);
    // R4: compare zeroes result even with unequal operands
    apply(16'h1234, 16'h4321, 16'h0, 0, 0, 2'b11);
    check_val("R4 cmp zero", result, 16'h0000);
    check_val("R5 cmp unequal", {15'b0, equal}, 16'h0000);

    // Sweep: R1 R2 R3 R4 R5 R6 R7
    for (int f = 0; f < 4; f++)
      for (int sa = 0; sa < 2; sa++)
        for (int sb = 0; sb < 2; sb++)
          for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++)
              for (int ii = 0; ii < 7; ii++) begin
                logic [15:0] ea, eb;
                string tag;
                apply(VALS[ia], VALS[ib], INSTRS[ii], sa[0], sb[0], f[1:0]);
                ea = exp_a(VALS[ia], INSTRS[ii], sa[0]);
                eb = exp_b(VALS[ib], INSTRS[ii], sb[0]);
                case (f)
                  0: tag = "R1 add";
                  1: tag = "R2 nand";
                  2: tag = "R3 pass";
                  default: tag = "R4 cmp";
                endcase
                check_val(tag, result, exp_res(ea, eb, f[1:0]));
                check_val("R5 equal", {15'b0, equal}, {15'b0, ea == eb});
              end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule